// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is a single programmable performance counter. Every clock it looks at a bank of event lines, arranged as groups of eight sub-event lines with one group per event code. An 8-bit event code picks a group, and an 8-bit sub-event mask picks which lines of that group take part. The number of selected lines that are high in a cycle is the raw per-cycle event count.

The raw count goes through three optional qualifiers before it reaches a 48-bit accumulator. The first is a threshold compare. The second is an inversion of that compare. The third is a rising-edge detector. With all qualifiers off, the accumulator adds the raw count each cycle. Software programs the control word and reads or writes the accumulator through a small register port. Writes are synchronous, and the read data is a combinational mux.

The block has no overflow interrupt and cannot be chained with other counters. An overflow wraps the accumulator silently.

Top module: `qev_counter`

## Requirements
- R1: Event code `e` (control bits [7:0]) selects lines `evtLines[e*8 +: 8]`. Mask bit `k` (control bits [15:8]) enables line `k` of that group. With threshold zero, each enabled cycle adds the number of selected lines that are high, so a mask of several bits counts the union of those sub-events. An event code at or above `NUM_EVT` selects nothing.
- R2: With a nonzero threshold (control bits [31:24]) and invert clear, the counter adds exactly 1 in each enabled cycle whose raw count is at least the threshold, and 0 otherwise.
- R3: With a nonzero threshold and invert (control bit 17) set, the counter adds 1 in each enabled cycle whose raw count is below the threshold, and 0 otherwise.
- R4: With the threshold at zero, the invert bit has no effect.
- R5: With edge mode (control bit 16) set, the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous cycle. With threshold zero, that condition is "raw count nonzero".
- R6: With enable (control bit 18) clear, the counter holds its value. The edge history is cleared, so the first true cycle after re-enabling counts as a rising edge.
- R7: A write with `regWrSel`=1 loads the counter. A write with `regWrSel`=0 loads the control word. `regRdData` shows the counter when `regRdSel`=1. It shows the control word when `regRdSel`=0, zero-extended, with bits [23:19] reading as zero.
- R8: A counter write in the same cycle as an increment wins, and the counter takes the written value.
- R9: The counter wraps modulo 2^48 without any other effect.
- R10: After reset, the counter and the control word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtLines | input | NUM_EVT*8 | Per-cycle sub-event lines, eight per event code |
| regWr | input | 1 | Register write strobe |
| regWrSel | input | 1 | Write target: 1 selects the counter, 0 selects the control word |
| regWrData | input | CNT_W | Write data |
| regRdSel | input | 1 | Read source: 1 selects the counter, 0 selects the control word |
| regRdData | output | CNT_W | Read data |

## Verification
The hardest state to reach is the edge history around an enable change. The history flop is invisible at the ports. It only shows when a condition that stays high through a disable and re-enable is counted again. To reach it, the stimulus counts a held condition in edge mode and shows that the repeat cycles add nothing. It then drops enable through a control write while the lines stay high, and finally re-enables with the lines still high, where a single new increment is expected. The carry-out at the 48-bit boundary is reached by loading a value just below the limit and then adding a multi-event cycle.

// File: rtl/qev_pkg.sv
package qev_pkg;
  localparam int SUB_W = 8;

  // Control word layout (LSB first): event code, sub-event mask, edge, invert,
  // enable, spare bits that read zero, threshold.
  typedef struct packed {
    logic [7:0] cmask;
    logic [4:0] rsvd;
    logic       enable;
    logic       invert;
    logic       edgeMode;
    logic [7:0] umask;
    logic [7:0] evtSel;
  } qev_ctrl_t;

  localparam int CTRL_W = $bits(qev_ctrl_t);

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
    logic bump;
  } qev_strobe_t;
endpackage

// File: rtl/qev_ctrl.sv
module qev_ctrl
  import qev_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int INC_W   = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_EVT*SUB_W-1:0] evtLines,
  input  logic                     regWr,
  input  logic                     regWrSel,
  input  logic [CTRL_W-1:0]        ctrlWrData,
  output qev_ctrl_t                ctrlQ,
  output qev_strobe_t              strobe,
  output logic [INC_W-1:0]         incAmt
);
  qev_ctrl_t        wrCtrl;
  logic [SUB_W-1:0] grp;
  logic [SUB_W-1:0] hits;
  logic [INC_W-1:0] evCount;
  logic             threshZero;
  logic             meetsThr;
  logic             cond;
  logic             prevCond;
  logic             rise;

  always_comb begin
    wrCtrl      = qev_ctrl_t'(ctrlWrData);
    wrCtrl.rsvd = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  ctrlQ <= '0;
    else if (regWr && !regWrSel) ctrlQ <= wrCtrl;
  end

  // Group select by event code; out-of-range codes select nothing.
  always_comb begin
    grp = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (ctrlQ.evtSel == 8'(i)) grp = evtLines[i*SUB_W +: SUB_W];
    end
  end

  assign hits = grp & ctrlQ.umask;

  always_comb begin
    evCount = '0;
    for (int k = 0; k < SUB_W; k++) evCount = evCount + INC_W'(hits[k]);
  end

  assign threshZero = (ctrlQ.cmask == 8'd0);
  assign meetsThr   = (8'(evCount) >= ctrlQ.cmask);
  assign cond       = threshZero ? (evCount != '0)
                                 : (ctrlQ.invert ? !meetsThr : meetsThr);
  assign rise       = cond && !prevCond;

  always_ff @(posedge clk) begin
    if (!rstN) prevCond <= 1'b0;
    else       prevCond <= ctrlQ.enable ? cond : 1'b0;
  end

  always_comb begin
    if (ctrlQ.edgeMode)  incAmt = INC_W'(rise);
    else if (threshZero) incAmt = evCount;
    else                 incAmt = INC_W'(cond);
  end

  assign strobe.load = regWr && regWrSel;
  assign strobe.bump = ctrlQ.enable;
endmodule

// File: rtl/qev_datapath.sv
module qev_datapath
  import qev_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  qev_strobe_t      strobe,
  input  logic [INC_W-1:0] incAmt,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cntQ
);
  always_ff @(posedge clk) begin
    if (!rstN)            cntQ <= '0;
    else if (strobe.load) cntQ <= loadVal;
    else if (strobe.bump) cntQ <= cntQ + CNT_W'(incAmt);
  end
endmodule

// File: rtl/qev_counter.sv
module qev_counter
  import qev_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int CNT_W   = 48
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_EVT*SUB_W-1:0] evtLines,
  input  logic                     regWr,
  input  logic                     regWrSel,
  input  logic [CNT_W-1:0]         regWrData,
  input  logic                     regRdSel,
  output logic [CNT_W-1:0]         regRdData
);
  localparam int INC_W = $clog2(SUB_W + 1);

  qev_ctrl_t        ctrlQ;
  qev_strobe_t      strobe;
  logic [INC_W-1:0] incAmt;
  logic [CNT_W-1:0] cntQ;

  qev_ctrl #(.NUM_EVT(NUM_EVT), .INC_W(INC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtLines(evtLines), .regWr(regWr),
    .regWrSel(regWrSel), .ctrlWrData(regWrData[CTRL_W-1:0]),
    .ctrlQ(ctrlQ), .strobe(strobe), .incAmt(incAmt)
  );

  qev_datapath #(.CNT_W(CNT_W), .INC_W(INC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .incAmt(incAmt),
    .loadVal(regWrData), .cntQ(cntQ)
  );

  assign regRdData = regRdSel ? cntQ : CNT_W'(ctrlQ);
endmodule

// File: rtl/qev_checker.sv
module qev_checker
  import qev_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int INC_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input qev_ctrl_t        ctrlQ,
  input qev_strobe_t      strobe,
  input logic [INC_W-1:0] incAmt,
  input logic [CNT_W-1:0] cntQ,
  input logic [CNT_W-1:0] regWrData,
  input logic             regWr,
  input logic             regWrSel
);
  p_union_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.enable && !strobe.load) |=>
      ((cntQ - $past(cntQ)) <= CNT_W'($countones($past(ctrlQ.umask)))));

  p_thresh_unit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.enable && ctrlQ.cmask != 8'd0 && !strobe.load) |=>
      ((cntQ - $past(cntQ)) <= CNT_W'(1)));

  p_edge_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.enable && ctrlQ.edgeMode && incAmt != '0 && !(regWr && !regWrSel)) |=>
      (incAmt == '0));

  p_hold_disabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ.enable && !strobe.load) |=> $stable(cntQ));

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (cntQ == $past(regWrData)));
endmodule

bind qev_counter qev_checker #(.CNT_W(CNT_W), .INC_W(INC_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlQ(ctrlQ), .strobe(strobe), .incAmt(incAmt),
  .cntQ(cntQ), .regWrData(regWrData), .regWr(regWr), .regWrSel(regWrSel)
);

// File: tb/qev_counter_bench.sv
`timescale 1ns/1ps
module qev_counter_bench;
  localparam int NE = 4;
  localparam int CW = 48;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NE*8-1:0] evtLines = '0;
  logic          regWr = 1'b0;
  logic          regWrSel = 1'b0;
  logic [CW-1:0] regWrData = '0;
  logic          regRdSel = 1'b1;
  logic [CW-1:0] regRdData;

  always #2 clk = ~clk;

  qev_counter #(.NUM_EVT(NE), .CNT_W(CW)) u_qev_counter (
    .clk(clk), .rstN(rstN), .evtLines(evtLines), .regWr(regWr),
    .regWrSel(regWrSel), .regWrData(regWrData), .regRdSel(regRdSel),
    .regRdData(regRdData)
  );

  typedef struct { logic [CW-1:0] exp; string tag; } sb_item_t;
  sb_item_t sbQ[$];
  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  // Reference state built from the requirements
  logic [CW-1:0] mCnt = '0;
  logic [7:0] mSel = 0, mMask = 0, mThr = 0;
  logic mEdge = 0, mInv = 0, mEn = 0, mPrev = 0;

  function automatic logic [CW-1:0] mkCtrl(input logic [7:0] sel, input logic [7:0] mask,
      input logic edg, input logic inv, input logic en, input logic [7:0] thr);
    return CW'({thr, 5'b0, en, inv, edg, mask, sel});
  endfunction

  task automatic step(input logic [NE*8-1:0] lines, input logic wr, input logic wsel,
                      input logic [CW-1:0] wdata, input string tag);
    logic [7:0] grp;
    int cnt;
    logic cond, inc1;
    int inc;
    @(negedge clk); #1;
    evtLines = lines; regWr = wr; regWrSel = wsel; regWrData = wdata;
    grp = '0;
    for (int i = 0; i < NE; i++) if (mSel == 8'(i)) grp = lines[i*8 +: 8];
    cnt = $countones(grp & mMask);
    if (mThr == 0) cond = (cnt != 0);
    else cond = mInv ? (cnt < int'(mThr)) : (cnt >= int'(mThr));
    inc1 = cond && !mPrev;
    if (mEdge) inc = int'(inc1);
    else if (mThr == 0) inc = cnt;
    else inc = int'(cond);
    if (wr && wsel) mCnt = wdata;
    else if (mEn) mCnt = mCnt + CW'(inc);
    mPrev = mEn ? cond : 1'b0;
    if (wr && !wsel) begin
      mSel = wdata[7:0]; mMask = wdata[15:8]; mEdge = wdata[16];
      mInv = wdata[17]; mEn = wdata[18]; mThr = wdata[31:24];
    end
    @(posedge clk); #1;
    regWr = 1'b0;
    sbQ.push_back('{exp: mCnt, tag: tag});
  endtask

  task automatic wrCtrl(input logic [CW-1:0] v, input string tag);
    step('0, 1'b1, 1'b0, v, tag);
  endtask

  task automatic direct(input logic sel, input logic [CW-1:0] exp, input string tag);
    @(negedge clk); #1;
    regRdSel = sel; #1;
    nChecks++;
    if (regRdData !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, regRdData, exp);
    end
    regRdSel = 1'b1;
  endtask

  // Monitor: compares the counter after each driven cycle
  always @(negedge clk) begin
    if (rstN && sbQ.size() > 0) begin
      sb_item_t it;
      it = sbQ.pop_front();
      nChecks++;
      if (regRdData !== it.exp) begin
        nFail++;
        $display("FAIL %s: got %0h expected %0h", it.tag, regRdData, it.exp);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R10 reset state
    direct(1'b1, '0, "R10 counter after reset");
    direct(1'b0, '0, "R10 control after reset");
    // R7 control write with spare and high bits set reads back masked
    wrCtrl(mkCtrl(8'd2, 8'h07, 0, 0, 1, 8'd0) | (CW'(5'h1f) << 19) | (CW'(16'hABCD) << 32),
           "R7 control write");
    direct(1'b0, mkCtrl(8'd2, 8'h07, 0, 0, 1, 8'd0), "R7 control readback");
    // R1 union counting of selected group
    step(32'h00FF_0000, 0, 0, '0, "R1 mask 07 all lines");
    step(32'hFF09_FFFF, 0, 0, '0, "R1 lines 0 and 3 only");
    step(32'h0006_0000, 0, 0, '0, "R1 two lines");
    // R7 counter write and R8 priority
    step('0, 1, 1, CW'(100), "R7 counter write");
    step(32'h00FF_0000, 1, 1, CW'(500), "R8 write beats increment");
    step(32'h00FF_0000, 0, 0, '0, "R1 after write");
    // R1 out-of-range event code
    wrCtrl(mkCtrl(8'd9, 8'hFF, 0, 0, 1, 8'd0), "R1 bad code ctrl");
    step(32'hFFFF_FFFF, 0, 0, '0, "R1 out-of-range code");
    // R2 threshold
    wrCtrl(mkCtrl(8'd0, 8'hFF, 0, 0, 1, 8'd3), "R2 ctrl");
    step(32'h0000_0007, 0, 0, '0, "R2 equal to threshold");
    step(32'h0000_0003, 0, 0, '0, "R2 below threshold");
    step(32'h0000_00FF, 0, 0, '0, "R2 above threshold");
    // R3 inverted threshold
    wrCtrl(mkCtrl(8'd0, 8'hFF, 0, 1, 1, 8'd3), "R3 ctrl");
    step(32'h0000_0003, 0, 0, '0, "R3 below counts");
    step(32'h0000_0007, 0, 0, '0, "R3 at threshold no count");
    step(32'h0000_0000, 0, 0, '0, "R3 zero counts");
    // R4 invert with zero threshold
    wrCtrl(mkCtrl(8'd0, 8'hFF, 0, 1, 1, 8'd0), "R4 ctrl");
    step(32'h0000_0005, 0, 0, '0, "R4 invert ignored");
    // R5 edge with threshold 2 on group 1
    wrCtrl(mkCtrl(8'd1, 8'hFF, 1, 0, 1, 8'd2), "R5 ctrl");
    step(32'h0000_0300, 0, 0, '0, "R5 first rise");
    step(32'h0000_0700, 0, 0, '0, "R5 held");
    step(32'h0000_FF00, 0, 0, '0, "R5 held wide");
    step(32'h0000_0000, 0, 0, '0, "R5 fall");
    step(32'h0000_0300, 0, 0, '0, "R5 second rise");
    step(32'h0000_0100, 0, 0, '0, "R5 below");
    step(32'h0000_0300, 0, 0, '0, "R5 third rise");
    // R5 edge with threshold zero
    wrCtrl(mkCtrl(8'd1, 8'hFF, 1, 0, 1, 8'd0), "R5 ctrl thr0");
    step(32'h0000_0100, 0, 0, '0, "R5 thr0 rise");
    step(32'h0000_0100, 0, 0, '0, "R5 thr0 held");
    step(32'h0000_0000, 0, 0, '0, "R5 thr0 fall");
    step(32'h0000_0200, 0, 0, '0, "R5 thr0 rise again");
    // R6 disable holds and clears edge history
    step(32'h0000_0100, 1, 0, mkCtrl(8'd1, 8'hFF, 1, 0, 0, 8'd0), "R6 disable write");
    step(32'h0000_0100, 0, 0, '0, "R6 hold while disabled");
    step(32'h0000_0FF00, 0, 0, '0, "R6 hold many events");
    step(32'h0000_0100, 1, 0, mkCtrl(8'd1, 8'hFF, 1, 0, 1, 8'd0), "R6 enable write");
    step(32'h0000_0100, 0, 0, '0, "R6 rise after re-enable");
    // R9 wrap
    wrCtrl(mkCtrl(8'd0, 8'hFF, 0, 0, 1, 8'd0), "R9 ctrl");
    step(32'h0000_0000, 1, 1, {CW{1'b1}} - CW'(1), "R9 load near top");
    step(32'h0000_0007, 0, 0, '0, "R9 wrap past zero");
    step(32'h0000_0000, 0, 0, '0, "R9 after wrap");
    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule